// File: doc/BRIEF.md
# Event Fragment Receiver and Checker

This block sits on the back-end side of a front-end readout link. It takes one 16-bit fragment word per clock, together with an active-low data-valid flag. An all-ones word opens a fragment and an all-zeros word with data-valid high closes it. Between the two, the block walks through two header words, a configured number of samples and a trailer word. For each word it decodes it raises a one-cycle field strobe, and each strobe comes with the fields extracted from that word.

Each sample is one sample header followed by eight ADC words per configured gain. The block numbers the ADC words within a sample by channel (0..7) and by gain slot. Four sticky error flags collect problems with the stream. The parity flag reports words that break the odd-parity rule. The length flag reports fragments whose word count does not match the configuration. The framing flag reports words outside a fragment or a misplaced delimiter. The format flag reports illegal field contents. A fragment-complete pulse marks every closed fragment.

Top module: `frag_rx`

## Requirements
- R1: After reset every strobe, the fragment-complete pulse and all four error flags are zero.
- R2: A word 0xFFFF with data-valid low opens a fragment. The next two accepted words are decoded one cycle after they are presented, and at most one field strobe is high in any cycle. The first header gives the ADC id (bits 11:8), the phase (bits 7:5) and the event number (bits 4:0). The second header gives a 12-bit crossing id (bits 11:0).
- R3: A sample header reports the cell number (bits 7:0), the first flag (bit 11), the last flag (bit 10), the back-porch flag (bit 9), the test flag (bit 8) and the zero-based sample index.
- R4: Each sample header is followed by 8 × gains ADC words. Each one reports its value (bits 11:0) and gain code (bits 13:12). It also reports the channel, which is its position modulo 8, and the gain slot, which is its position divided by 8.
- R5: The word after the last ADC word of the last sample is the trailer. It reports the status in bits 8:1 and two correction flags in bits 10:9.
- R6: An all-zeros word with data-valid high closes an open fragment and raises the fragment-complete pulse one cycle later. In idle, such words have no effect.
- R7: Any word with data-valid low other than 0x0000 and 0xFFFF must have an odd number of ones. A word with an even count sets the parity flag.
- R8: At close, the count of words from the start word through the last word before the end word must equal 4 + samples × (1 + 8 × gains). Any other count sets the length flag.
- R9: The framing flag is set by any of the following: a start word while a fragment is open, which also restarts decoding; a non-zero word with data-valid high, which is otherwise ignored; a 0x0000 word with data-valid low; a non-delimiter word with data-valid low outside a fragment.
- R10: The format flag is set by any of the following: an ADC gain code of 00; a trailer whose bit 0 or bit 11 is not one, or whose bit 12, 13 or 15 is not zero; a first flag that is not set on exactly the first sample header; a last flag that is not set on exactly the last sample header.
- R11: Error flags stay set through later correct fragments until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 16 | Fragment word |
| dav_n_i | input | 1 | Data valid, active low |
| cfg_samples_i | input | SMP_W | Samples per fragment (1 or more) |
| cfg_gains_i | input | GAIN_W | Gains per sample (1..3) |
| hdr_vld_o | output | 1 | First header strobe |
| hdr_adc_id_o | output | 4 | ADC id |
| hdr_phase_o | output | 3 | Phase |
| hdr_evt_o | output | 5 | Event number |
| bcid_vld_o | output | 1 | Second header strobe |
| bcid_o | output | 12 | Crossing id |
| smp_vld_o | output | 1 | Sample header strobe |
| smp_idx_o | output | SMP_W | Sample index |
| smp_cell_o | output | 8 | Cell number |
| smp_first_o | output | 1 | First flag |
| smp_last_o | output | 1 | Last flag |
| smp_bp_o | output | 1 | Back-porch flag |
| smp_test_o | output | 1 | Test flag |
| adc_vld_o | output | 1 | ADC word strobe |
| adc_val_o | output | 12 | ADC value |
| adc_gain_o | output | 2 | Gain code |
| adc_chan_o | output | 3 | Channel in sample |
| adc_slot_o | output | GAIN_W | Gain slot |
| trl_vld_o | output | 1 | Trailer strobe |
| trl_status_o | output | 8 | Trailer status |
| trl_edc_o | output | 2 | Correction flags |
| frag_done_o | output | 1 | Fragment closed pulse |
| err_parity_o | output | 1 | Sticky parity error |
| err_length_o | output | 1 | Sticky length error |
| err_framing_o | output | 1 | Sticky framing error |
| err_format_o | output | 1 | Sticky format error |

## Verification
The hardest situation to reach is a fragment that is cut short or restarted. In that case the sequencer's position in the sample structure and its word count disagree with what the configuration implies. The stimulus drives a start word into the middle of a half-sent fragment and then sends a full fragment. It also drops the final ADC word, so that the trailer is taken as ADC data. Finally it inserts an extra word after the trailer. In each case the framing, length and format flags and the number of completed fragments are compared against values worked out from the word counts.

// File: rtl/frx_pkg.sv
package frx_pkg;

    localparam int WORD_W     = 16;
    localparam int CH_PER_SMP = 8;
    localparam int BIT_FIRST  = 11;
    localparam int BIT_LAST   = 10;
    localparam int BIT_BP     = 9;
    localparam int BIT_TEST   = 8;

    // payload keeps every bit but the parity bit (bit 14); index 14 holds word bit 15
    typedef logic [WORD_W-2:0] payload_t;

    typedef enum logic [2:0] {
        K_NONE, K_HDR1, K_HDR2, K_SHDR, K_ADC, K_TRL
    } word_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR1, S_HDR2, S_SHDR, S_ADC, S_TRL, S_TAIL
    } seq_state_e;

    typedef struct packed {
        logic start;
        logic fin;
        logic par_ok;
    } word_class_t;

    function automatic word_class_t classify(input logic [WORD_W-1:0] w);
        word_class_t c;
        c.start  = &w;
        c.fin    = ~|w;
        c.par_ok = ^w;
        return c;
    endfunction

    function automatic payload_t strip_parity(input logic [WORD_W-1:0] w);
        return {w[15], w[13:0]};
    endfunction

    function automatic logic trailer_ok(input payload_t p);
        return p[0] & p[11] & ~p[12] & ~p[13] & ~p[14];
    endfunction

endpackage

// File: rtl/frx_classify.sv
module frx_classify
    import frx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output word_class_t       cls,
    output payload_t          payload
);

    always_comb begin
        cls     = classify(word);
        payload = strip_parity(word);
    end

endmodule

// File: rtl/frx_sequencer.sv
module frx_sequencer
    import frx_pkg::*;
#(
    parameter int SMP_W  = 4,
    parameter int GAIN_W = 2,
    parameter int CNT_W  = 10,
    parameter int ADC_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dav_n,
    input  word_class_t       cls,
    input  logic [SMP_W-1:0]  cfg_smp,
    input  logic [GAIN_W-1:0] cfg_gain,
    output word_kind_e        kind,
    output logic [SMP_W-1:0]  smp_idx,
    output logic [ADC_W-1:0]  adc_pos,
    output logic              close,
    output logic              len_err,
    output logic              frm_err
);

    seq_state_e         st, st_n;
    logic [CNT_W-1:0]   wcnt, wcnt_n;
    logic [SMP_W-1:0]   smp_r, smp_n;
    logic [ADC_W-1:0]   adc_r, adc_n;
    logic [CNT_W-1:0]   exp_len;
    logic [ADC_W-1:0]   adc_last;
    logic [SMP_W-1:0]   smp_last;

    assign exp_len  = CNT_W'(4) + CNT_W'(cfg_smp)
                    * (CNT_W'(1) + CNT_W'(cfg_gain) * CNT_W'(CH_PER_SMP));
    assign adc_last = ADC_W'({cfg_gain, 3'b000}) - ADC_W'(1);
    assign smp_last = cfg_smp - SMP_W'(1);

    always_comb begin
        st_n    = st;
        wcnt_n  = wcnt;
        smp_n   = smp_r;
        adc_n   = adc_r;
        kind    = K_NONE;
        close   = 1'b0;
        len_err = 1'b0;
        frm_err = 1'b0;
        if (dav_n) begin
            if (!cls.fin) begin
                frm_err = 1'b1;
            end else if (st != S_IDLE) begin
                close   = 1'b1;
                len_err = (wcnt != exp_len);
                st_n    = S_IDLE;
            end
        end else if (cls.start) begin
            if (st != S_IDLE) frm_err = 1'b1;
            st_n   = S_HDR1;
            wcnt_n = CNT_W'(1);
            smp_n  = '0;
            adc_n  = '0;
        end else if (cls.fin || st == S_IDLE) begin
            frm_err = 1'b1;
        end else begin
            if (wcnt != '1) wcnt_n = wcnt + CNT_W'(1);
            case (st)
                S_HDR1: begin kind = K_HDR1; st_n = S_HDR2; end
                S_HDR2: begin kind = K_HDR2; st_n = S_SHDR; end
                S_SHDR: begin kind = K_SHDR; st_n = S_ADC; adc_n = '0; end
                S_ADC: begin
                    kind = K_ADC;
                    if (adc_r == adc_last) begin
                        adc_n = '0;
                        if (smp_r == smp_last) begin
                            st_n = S_TRL;
                        end else begin
                            smp_n = smp_r + SMP_W'(1);
                            st_n  = S_SHDR;
                        end
                    end else begin
                        adc_n = adc_r + ADC_W'(1);
                    end
                end
                S_TRL:   begin kind = K_TRL; st_n = S_TAIL; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            wcnt  <= '0;
            smp_r <= '0;
            adc_r <= '0;
        end else begin
            st    <= st_n;
            wcnt  <= wcnt_n;
            smp_r <= smp_n;
            adc_r <= adc_n;
        end
    end

    assign smp_idx = smp_r;
    assign adc_pos = adc_r;

endmodule

// File: rtl/frx_decoder.sv
module frx_decoder
    import frx_pkg::*;
#(
    parameter int SMP_W  = 4,
    parameter int GAIN_W = 2,
    parameter int ADC_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  word_kind_e        kind,
    input  payload_t          pl,
    input  logic [SMP_W-1:0]  smp_idx,
    input  logic [ADC_W-1:0]  adc_pos,
    input  logic [SMP_W-1:0]  cfg_smp,
    output logic              fmt_err,
    output logic              hdr_vld,
    output logic [3:0]        hdr_adc_id,
    output logic [2:0]        hdr_phase,
    output logic [4:0]        hdr_evt,
    output logic              bcid_vld,
    output logic [11:0]       bcid,
    output logic              smp_vld,
    output logic [SMP_W-1:0]  smp_idx_q,
    output logic [7:0]        smp_cell,
    output logic              smp_first,
    output logic              smp_last,
    output logic              smp_bp,
    output logic              smp_test,
    output logic              adc_vld,
    output logic [11:0]       adc_val,
    output logic [1:0]        adc_gain,
    output logic [2:0]        adc_chan,
    output logic [GAIN_W-1:0] adc_slot,
    output logic              trl_vld,
    output logic [7:0]        trl_status,
    output logic [1:0]        trl_edc
);

    logic is_first, is_last;

    assign is_first = (smp_idx == '0);
    assign is_last  = (smp_idx == cfg_smp - SMP_W'(1));

    always_comb begin
        unique case (kind)
            K_SHDR:  fmt_err = (pl[BIT_FIRST] != is_first) || (pl[BIT_LAST] != is_last);
            K_ADC:   fmt_err = (pl[13:12] == 2'b00);
            K_TRL:   fmt_err = !trailer_ok(pl);
            default: fmt_err = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_vld    <= 1'b0;
            hdr_adc_id <= '0;
            hdr_phase  <= '0;
            hdr_evt    <= '0;
            bcid_vld   <= 1'b0;
            bcid       <= '0;
            smp_vld    <= 1'b0;
            smp_idx_q  <= '0;
            smp_cell   <= '0;
            smp_first  <= 1'b0;
            smp_last   <= 1'b0;
            smp_bp     <= 1'b0;
            smp_test   <= 1'b0;
            adc_vld    <= 1'b0;
            adc_val    <= '0;
            adc_gain   <= '0;
            adc_chan   <= '0;
            adc_slot   <= '0;
            trl_vld    <= 1'b0;
            trl_status <= '0;
            trl_edc    <= '0;
        end else begin
            hdr_vld  <= (kind == K_HDR1);
            bcid_vld <= (kind == K_HDR2);
            smp_vld  <= (kind == K_SHDR);
            adc_vld  <= (kind == K_ADC);
            trl_vld  <= (kind == K_TRL);
            if (kind == K_HDR1) begin
                hdr_adc_id <= pl[11:8];
                hdr_phase  <= pl[7:5];
                hdr_evt    <= pl[4:0];
            end
            if (kind == K_HDR2) bcid <= pl[11:0];
            if (kind == K_SHDR) begin
                smp_idx_q <= smp_idx;
                smp_cell  <= pl[7:0];
                smp_first <= pl[BIT_FIRST];
                smp_last  <= pl[BIT_LAST];
                smp_bp    <= pl[BIT_BP];
                smp_test  <= pl[BIT_TEST];
            end
            if (kind == K_ADC) begin
                adc_val  <= pl[11:0];
                adc_gain <= pl[13:12];
                adc_chan <= adc_pos[2:0];
                adc_slot <= GAIN_W'(adc_pos >> 3);
            end
            if (kind == K_TRL) begin
                trl_status <= pl[8:1];
                trl_edc    <= pl[10:9];
            end
        end
    end

endmodule

// File: rtl/frag_rx.sv
module frag_rx
    import frx_pkg::*;
#(
    parameter int SMP_W  = 4,
    parameter int GAIN_W = 2,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       word_i,
    input  logic              dav_n_i,
    input  logic [SMP_W-1:0]  cfg_samples_i,
    input  logic [GAIN_W-1:0] cfg_gains_i,
    output logic              hdr_vld_o,
    output logic [3:0]        hdr_adc_id_o,
    output logic [2:0]        hdr_phase_o,
    output logic [4:0]        hdr_evt_o,
    output logic              bcid_vld_o,
    output logic [11:0]       bcid_o,
    output logic              smp_vld_o,
    output logic [SMP_W-1:0]  smp_idx_o,
    output logic [7:0]        smp_cell_o,
    output logic              smp_first_o,
    output logic              smp_last_o,
    output logic              smp_bp_o,
    output logic              smp_test_o,
    output logic              adc_vld_o,
    output logic [11:0]       adc_val_o,
    output logic [1:0]        adc_gain_o,
    output logic [2:0]        adc_chan_o,
    output logic [GAIN_W-1:0] adc_slot_o,
    output logic              trl_vld_o,
    output logic [7:0]        trl_status_o,
    output logic [1:0]        trl_edc_o,
    output logic              frag_done_o,
    output logic              err_parity_o,
    output logic              err_length_o,
    output logic              err_framing_o,
    output logic              err_format_o
);

    localparam int MAX_ADC = CH_PER_SMP * ((1 << GAIN_W) - 1);
    localparam int ADC_W   = $clog2(MAX_ADC);

    word_class_t        cls;
    payload_t           pl;
    word_kind_e         kind;
    logic [SMP_W-1:0]   smp_idx;
    logic [ADC_W-1:0]   adc_pos;
    logic               close, len_ev, frm_ev, fmt_ev, par_ev;

    frx_classify u_cls (
        .word    (word_i),
        .cls     (cls),
        .payload (pl)
    );

    frx_sequencer #(
        .SMP_W (SMP_W), .GAIN_W (GAIN_W), .CNT_W (CNT_W), .ADC_W (ADC_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .dav_n    (dav_n_i),
        .cls      (cls),
        .cfg_smp  (cfg_samples_i),
        .cfg_gain (cfg_gains_i),
        .kind     (kind),
        .smp_idx  (smp_idx),
        .adc_pos  (adc_pos),
        .close    (close),
        .len_err  (len_ev),
        .frm_err  (frm_ev)
    );

    frx_decoder #(
        .SMP_W (SMP_W), .GAIN_W (GAIN_W), .ADC_W (ADC_W)
    ) u_dec (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .pl         (pl),
        .smp_idx    (smp_idx),
        .adc_pos    (adc_pos),
        .cfg_smp    (cfg_samples_i),
        .fmt_err    (fmt_ev),
        .hdr_vld    (hdr_vld_o),
        .hdr_adc_id (hdr_adc_id_o),
        .hdr_phase  (hdr_phase_o),
        .hdr_evt    (hdr_evt_o),
        .bcid_vld   (bcid_vld_o),
        .bcid       (bcid_o),
        .smp_vld    (smp_vld_o),
        .smp_idx_q  (smp_idx_o),
        .smp_cell   (smp_cell_o),
        .smp_first  (smp_first_o),
        .smp_last   (smp_last_o),
        .smp_bp     (smp_bp_o),
        .smp_test   (smp_test_o),
        .adc_vld    (adc_vld_o),
        .adc_val    (adc_val_o),
        .adc_gain   (adc_gain_o),
        .adc_chan   (adc_chan_o),
        .adc_slot   (adc_slot_o),
        .trl_vld    (trl_vld_o),
        .trl_status (trl_status_o),
        .trl_edc    (trl_edc_o)
    );

    assign par_ev = !dav_n_i && !cls.start && !cls.fin && !cls.par_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            frag_done_o   <= 1'b0;
            err_parity_o  <= 1'b0;
            err_length_o  <= 1'b0;
            err_framing_o <= 1'b0;
            err_format_o  <= 1'b0;
        end else begin
            frag_done_o   <= close;
            err_parity_o  <= err_parity_o  | par_ev;
            err_length_o  <= err_length_o  | len_ev;
            err_framing_o <= err_framing_o | frm_ev;
            err_format_o  <= err_format_o  | fmt_ev;
        end
    end

endmodule

// File: rtl/frx_checker.sv
module frx_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] word_i,
    input logic        dav_n_i,
    input logic        hdr_vld_o,
    input logic        bcid_vld_o,
    input logic        smp_vld_o,
    input logic        adc_vld_o,
    input logic [1:0]  adc_gain_o,
    input logic        trl_vld_o,
    input logic        frag_done_o,
    input logic        err_parity_o,
    input logic        err_length_o,
    input logic        err_framing_o,
    input logic        err_format_o
);

    logic any_strobe;
    assign any_strobe = hdr_vld_o | bcid_vld_o | smp_vld_o | adc_vld_o | trl_vld_o;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hdr_vld_o, bcid_vld_o, smp_vld_o, adc_vld_o, trl_vld_o})); // R2

    AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        any_strobe |-> $past(!dav_n_i)); // R2

    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        frag_done_o |-> $past(dav_n_i && word_i == 16'h0000)); // R6

    AST_PARITY_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (!dav_n_i && word_i != 16'h0000 && word_i != 16'hFFFF && !(^word_i))
        |=> err_parity_o); // R7

    AST_STRAY_WORD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (dav_n_i && word_i != 16'h0000) |=> err_framing_o); // R9

    AST_ZERO_GAIN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (adc_vld_o && adc_gain_o == 2'b00) |-> err_format_o); // R10

    AST_ERRORS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_parity_o || err_length_o || err_framing_o || err_format_o)
        |=> (err_parity_o || err_length_o || err_framing_o || err_format_o)); // R11

    AST_LENGTH_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_length_o |=> err_length_o); // R11

endmodule

bind frag_rx frx_checker u_frx_checker (
    .clk           (clk),
    .rst           (rst),
    .word_i        (word_i),
    .dav_n_i       (dav_n_i),
    .hdr_vld_o     (hdr_vld_o),
    .bcid_vld_o    (bcid_vld_o),
    .smp_vld_o     (smp_vld_o),
    .adc_vld_o     (adc_vld_o),
    .adc_gain_o    (adc_gain_o),
    .trl_vld_o     (trl_vld_o),
    .frag_done_o   (frag_done_o),
    .err_parity_o  (err_parity_o),
    .err_length_o  (err_length_o),
    .err_framing_o (err_framing_o),
    .err_format_o  (err_format_o)
);

// File: tb/test_frag_rx.sv
`timescale 1ns/1ps
module test_frag_rx;

    localparam int SMP_W  = 4;
    localparam int GAIN_W = 2;
    localparam int NV     = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] word_i = 16'h0000;
    logic dav_n_i = 1'b1;
    logic [SMP_W-1:0] cfg_samples_i = 4'd2;
    logic [GAIN_W-1:0] cfg_gains_i = 2'd1;

    logic hdr_vld_o, bcid_vld_o, smp_vld_o, adc_vld_o, trl_vld_o, frag_done_o;
    logic [3:0] hdr_adc_id_o;
    logic [2:0] hdr_phase_o;
    logic [4:0] hdr_evt_o;
    logic [11:0] bcid_o;
    logic [SMP_W-1:0] smp_idx_o;
    logic [7:0] smp_cell_o;
    logic smp_first_o, smp_last_o, smp_bp_o, smp_test_o;
    logic [11:0] adc_val_o;
    logic [1:0] adc_gain_o;
    logic [2:0] adc_chan_o;
    logic [GAIN_W-1:0] adc_slot_o;
    logic [7:0] trl_status_o;
    logic [1:0] trl_edc_o;
    logic err_parity_o, err_length_o, err_framing_o, err_format_o;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int adc_cnt = 0;
    int trl_cnt = 0;
    int tb_smp = 0;
    int tb_ch = 0;
    logic [2:0] last_chan;
    logic [GAIN_W-1:0] last_slot;

    always #10 clk = ~clk;

    frag_rx #(.SMP_W(SMP_W), .GAIN_W(GAIN_W)) i_frag_rx (
        .clk(clk), .rst(rst), .word_i(word_i), .dav_n_i(dav_n_i),
        .cfg_samples_i(cfg_samples_i), .cfg_gains_i(cfg_gains_i),
        .hdr_vld_o(hdr_vld_o), .hdr_adc_id_o(hdr_adc_id_o), .hdr_phase_o(hdr_phase_o),
        .hdr_evt_o(hdr_evt_o), .bcid_vld_o(bcid_vld_o), .bcid_o(bcid_o),
        .smp_vld_o(smp_vld_o), .smp_idx_o(smp_idx_o), .smp_cell_o(smp_cell_o),
        .smp_first_o(smp_first_o), .smp_last_o(smp_last_o), .smp_bp_o(smp_bp_o),
        .smp_test_o(smp_test_o), .adc_vld_o(adc_vld_o), .adc_val_o(adc_val_o),
        .adc_gain_o(adc_gain_o), .adc_chan_o(adc_chan_o), .adc_slot_o(adc_slot_o),
        .trl_vld_o(trl_vld_o), .trl_status_o(trl_status_o), .trl_edc_o(trl_edc_o),
        .frag_done_o(frag_done_o), .err_parity_o(err_parity_o),
        .err_length_o(err_length_o), .err_framing_o(err_framing_o),
        .err_format_o(err_format_o)
    );

    // entry: {dav_n, fix_parity, word[15:0], kind[2:0]}
    // kind: 0 none, 1 header1, 2 header2, 3 sample header, 4 adc, 5 trailer, 6 done
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h0000, 3'd0},
        {1'b0, 1'b0, 16'hFFFF, 3'd0},
        {1'b0, 1'b1, 16'h0A65, 3'd1},
        {1'b0, 1'b1, 16'h0123, 3'd2},
        {1'b0, 1'b1, 16'h0811, 3'd3},
        {1'b0, 1'b1, 16'h1100, 3'd4},
        {1'b0, 1'b1, 16'h1101, 3'd4},
        {1'b0, 1'b1, 16'h1102, 3'd4},
        {1'b0, 1'b1, 16'h1103, 3'd4},
        {1'b0, 1'b1, 16'h1FFC, 3'd4},
        {1'b0, 1'b1, 16'h1105, 3'd4},
        {1'b0, 1'b1, 16'h1006, 3'd4},
        {1'b0, 1'b1, 16'h1107, 3'd4},
        {1'b0, 1'b1, 16'h0612, 3'd3},
        {1'b0, 1'b1, 16'h2200, 3'd4},
        {1'b0, 1'b1, 16'h3201, 3'd4},
        {1'b0, 1'b1, 16'h2202, 3'd4},
        {1'b0, 1'b1, 16'h3203, 3'd4},
        {1'b0, 1'b1, 16'h2204, 3'd4},
        {1'b0, 1'b1, 16'h2A05, 3'd4},
        {1'b0, 1'b1, 16'h2206, 3'd4},
        {1'b0, 1'b1, 16'h3FFF, 3'd4},
        {1'b0, 1'b1, 16'h0C05, 3'd5},
        {1'b1, 1'b0, 16'h0000, 3'd6},
        {1'b1, 1'b0, 16'h0000, 3'd0}
    };

    function automatic logic [15:0] fp(input logic [15:0] w);
        logic [15:0] r;
        r = w;
        r[14] = 1'b0;
        if (!(^r)) r[14] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (frag_done_o) done_cnt++;
            if (trl_vld_o) trl_cnt++;
            if (adc_vld_o) begin
                adc_cnt++;
                last_chan = adc_chan_o;
                last_slot = adc_slot_o;
            end
        end
    end

    task automatic put(input logic [15:0] w, input logic d);
        @(negedge clk);
        word_i  = w;
        dav_n_i = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        word_i = 16'h0000;
        dav_n_i = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        done_cnt = 0;
        adc_cnt = 0;
        trl_cnt = 0;
    endtask

    // mode: 0 clean, 1 drop last adc, 2 zero gain, 3 no first flag,
    //       4 bad trailer, 5 even parity word, 6 extra word after trailer
    task automatic send_frag(input int ns, input int ng, input int mode);
        logic [15:0] w;
        put(16'hFFFF, 1'b0);
        put(fp(16'h0312), 1'b0);
        put(fp(16'h0456), 1'b0);
        for (int s = 0; s < ns; s++) begin
            w = 16'(s + 8'h20);
            if (s == 0 && mode != 3) w = w | 16'h0800;
            if (s == ns - 1) w = w | 16'h0400;
            put(fp(w), 1'b0);
            for (int a = 0; a < 8 * ng; a++) begin
                if (!(mode == 1 && s == ns - 1 && a == 8 * ng - 1)) begin
                    w = 16'(((a / 8) + 1) << 12) | 16'(a * 3 + s);
                    if (mode == 2 && s == 0 && a == 0) w = 16'h0005;
                    w = fp(w);
                    if (mode == 5 && s == 0 && a == 0) w = w ^ 16'h4000;
                    put(w, 1'b0);
                end
            end
        end
        put(fp(mode == 4 ? 16'h0800 : 16'h0801), 1'b0);
        if (mode == 6) put(fp(16'h0001), 1'b0);
        put(16'h0000, 1'b1);
        repeat (3) put(16'h0000, 1'b1);
    endtask

    task automatic check_vec(input logic [20:0] v);
        logic [15:0] w;
        logic [2:0] k;
        w = v[19] ? fp(v[18:3]) : v[18:3];
        k = v[2:0];
        chk("R2 strobes", {hdr_vld_o, bcid_vld_o, smp_vld_o, adc_vld_o, trl_vld_o, frag_done_o},
            {k == 3'd1, k == 3'd2, k == 3'd3, k == 3'd4, k == 3'd5, k == 3'd6});
        case (k)
            3'd1: chk("R2 header1", {hdr_adc_id_o, hdr_phase_o, hdr_evt_o}, {w[11:8], w[7:5], w[4:0]});
            3'd2: chk("R2 header2", bcid_o, w[11:0]);
            3'd3: begin
                chk("R3 sample header",
                    {smp_cell_o, smp_first_o, smp_last_o, smp_bp_o, smp_test_o, smp_idx_o},
                    {w[7:0], w[11], w[10], w[9], w[8], 4'(tb_smp)});
                tb_smp++;
                tb_ch = 0;
            end
            3'd4: begin
                chk("R4 adc word", {adc_val_o, adc_gain_o, adc_chan_o, adc_slot_o},
                    {w[11:0], w[13:12], 3'(tb_ch), 2'd0});
                tb_ch++;
            end
            3'd5: chk("R5 trailer", {trl_status_o, trl_edc_o}, {w[8:1], w[10:9]});
            3'd6: chk("R6 done", frag_done_o, 1'b1);
            default: ;
        endcase
        chk("R7 R8 R9 R10 no false error",
            {err_parity_o, err_length_o, err_framing_o, err_format_o}, 4'b0000);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs",
            {hdr_vld_o, bcid_vld_o, smp_vld_o, adc_vld_o, trl_vld_o, frag_done_o,
             err_parity_o, err_length_o, err_framing_o, err_format_o}, 10'd0);

        // table: two samples, one gain
        cfg_samples_i = 4'd2;
        cfg_gains_i = 2'd1;
        tb_smp = 0;
        tb_ch = 0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0) check_vec(VEC[i - 1]);
            word_i  = VEC[i][18:3] ^ (VEC[i][19] ? (fp(VEC[i][18:3]) ^ VEC[i][18:3]) : 16'h0000);
            dav_n_i = VEC[i][20];
        end
        @(negedge clk);
        check_vec(VEC[NV - 1]);
        repeat (3) put(16'h0000, 1'b1);
        chk("R6 idle zeros give no done", done_cnt, 32'd1);

        // R4 R5 R8: two samples, two gains
        do_reset();
        cfg_samples_i = 4'd2;
        cfg_gains_i = 2'd2;
        send_frag(2, 2, 0);
        chk("R4 adc word count", adc_cnt, 32'd32);
        chk("R4 last channel and slot", {last_chan, last_slot}, {3'd7, 2'd1});
        chk("R5 trailer seen", trl_cnt, 32'd1);
        chk("R8 clean length", {err_length_o, err_format_o, err_framing_o, err_parity_o}, 4'b0000);
        chk("R6 fragment closed", done_cnt, 32'd1);

        // R7 R11 R1: parity error, sticky, cleared by reset
        do_reset();
        cfg_samples_i = 4'd1;
        cfg_gains_i = 2'd1;
        send_frag(1, 1, 5);
        chk("R7 parity flagged", err_parity_o, 1'b1);
        send_frag(1, 1, 0);
        chk("R11 parity sticky", err_parity_o, 1'b1);
        do_reset();
        @(negedge clk);
        chk("R1 reset clears flags", {err_parity_o, err_length_o, err_framing_o, err_format_o}, 4'b0000);

        // R8 short fragment
        do_reset();
        send_frag(1, 1, 1);
        chk("R8 short fragment", err_length_o, 1'b1);
        chk("R6 short fragment closed", done_cnt, 32'd1);

        // R8 extra word after trailer
        do_reset();
        send_frag(1, 1, 6);
        chk("R8 extra word", {err_length_o, err_format_o}, 2'b10);

        // R9 restart in the middle of a fragment
        do_reset();
        put(16'hFFFF, 1'b0);
        put(fp(16'h0111), 1'b0);
        put(fp(16'h0222), 1'b0);
        send_frag(1, 1, 0);
        chk("R9 restart flagged", err_framing_o, 1'b1);
        chk("R9 restarted fragment length ok", err_length_o, 1'b0);
        chk("R9 restarted fragment closed", {done_cnt[7:0], trl_cnt[7:0]}, {8'd1, 8'd1});

        // R9 stray word with valid high
        do_reset();
        put(16'h1234, 1'b1);
        repeat (2) put(16'h0000, 1'b1);
        chk("R9 stray word", {err_framing_o, done_cnt[0]}, 2'b10);

        // R9 data word outside fragment
        do_reset();
        put(fp(16'h1001), 1'b0);
        repeat (2) put(16'h0000, 1'b1);
        chk("R9 data outside fragment", {err_framing_o, adc_cnt[0]}, 2'b10);

        // R10 format cases
        do_reset();
        send_frag(1, 1, 2);
        chk("R10 zero gain", {err_format_o, err_length_o}, 2'b10);
        do_reset();
        cfg_samples_i = 4'd2;
        send_frag(2, 1, 3);
        chk("R10 missing first flag", {err_format_o, err_length_o}, 2'b10);
        do_reset();
        cfg_samples_i = 4'd1;
        send_frag(1, 1, 4);
        chk("R10 bad trailer", {err_format_o, trl_cnt[0]}, 2'b11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule